// File: doc/BRIEF.md
# Open-Drain Capable Parallel I/O Port

This block is a 16-pin general-purpose I/O port that a processor reaches through a small register bus. Three registers are mapped: a direction register, an open-drain select register and a data latch. On the pad side each pin has an input level, an output value and an output enable, which connect directly to a tri-state pad cell. From the direction, open-drain and latch bits, the block works out whether each pin is driven and to what value.

Reads of the data register do not return the latch. They return the level seen at each pin after a two-flop synchroniser. Because of this, software can compare what it wrote with what is on the pin and detect a pin that another driver is overpowering. Only three pins can be switched to open-drain drive. The upper four pins are not wired to the port, so they are never driven and always read as zero. The data latch has no reset.

Bit numbering is MSB-first: pin number p is vector bit 15-p in every register and in every pin bus.

Top module: `gpio_od_port`

## Requirements
- R1: The registers sit at these bus offsets: direction at 0x0950, open-drain at 0x0954, data at 0x0956. Pin p maps to vector bit 15-p. Read data is combinational and valid in the cycle where `bus_sel`=1 and `bus_wr`=0. In every other cycle it is zero.
- R2: After reset the direction and open-drain registers both read 0, and every `pin_oe` bit is 0.
- R3: Only pins 9, 12 and 14 (vector mask 0x004A) hold open-drain bits. All other open-drain bits read 0, and writes to them are dropped.
- R4: A pin whose direction bit is 1 and whose open-drain bit is 0 has `pin_oe`=1, and its `pin_out` equals the latched bit.
- R5: A pin whose direction bit is 1 and whose open-drain bit is 1 behaves as follows. With a latched 0 it has `pin_oe`=1 and `pin_out`=0. With a latched 1 it has `pin_oe`=0.
- R6: A data read returns `pin_in` masked to pins 4 to 15 (0x0FFF), taken through two flops. A change on `pin_in` before clock edge N shows up on reads after edge N+1, not earlier.
- R7: A pin whose direction bit is 0 has `pin_oe`=0. Its data latch keeps a written value, and that value is driven once the direction bit is set.
- R8: Pins 0 to 3 (vector bits 15:12) read 0 in the direction and data registers, and are never driven.
- R9: An access to any other offset reads 0, and a write to it changes no register.
- R10: The data read returns the pin level even when that pin is an output, so an externally overpowered output reads back with the external level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe for this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 16 | Register offset |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational |
| pin_in | input | 16 | Level present at each pad |
| pin_out | output | 16 | Value offered to each pad driver |
| pin_oe | output | 16 | Pad driver enable, 1 = drive |

## Verification
The bench targets these faults and the symptom each one produces:
- An open-drain pin with a latched 1 that is still driven. This shows as `pin_oe` high where the pad should be released.
- Open-drain bits kept on pins that have none. This shows up in the read-back of the open-drain register and in a pin that floats wrongly.
- A data read that returns the latch instead of the pad. This hides an injected conflict on an output pin.
- A synchroniser with one stage too few or too many. This moves the first cycle in which a new level is read.
- Writes to unmapped offsets that reach a register, or the four unwired pins becoming drivable. Both show up in later read-backs and in the `pin_oe` value.

// File: rtl/gpio_od_pkg.sv
package gpio_od_pkg;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_DIR  = 2'd1,
    SEL_OD   = 2'd2,
    SEL_DAT  = 2'd3
  } reg_sel_e;

  // Pad enable for one pin: an open-drain pin releases the pad for a high.
  function automatic logic pad_enable(input logic dir_b, input logic od_b, input logic dat_b);
    return dir_b & ~(od_b & dat_b);
  endfunction

  // Value offered to the pad: an open-drain pin can only pull low.
  function automatic logic pad_value(input logic od_b, input logic dat_b);
    return od_b ? 1'b0 : dat_b;
  endfunction

  // Register write merge: only implemented bits take the new value.
  function automatic logic [15:0] merge_bits(input logic [15:0] old_v, input logic [15:0] new_v,
                                             input logic [15:0] impl);
    return (old_v & ~impl) | (new_v & impl);
  endfunction

endpackage

// File: rtl/gpio_od_sync.sv
module gpio_od_sync #(
  parameter int WIDTH  = 16,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] q_out
);
  logic [WIDTH-1:0] stage_q [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[0] <= '0;
          else        stage_q[0] <= d_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= '0;
          else        stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign q_out = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_od_drive.sv
module gpio_od_drive
  import gpio_od_pkg::*;
#(
  parameter int          WIDTH    = 16,
  parameter logic [15:0] PIN_MASK = 16'h0FFF
) (
  input  logic [WIDTH-1:0] dir_q,
  input  logic [WIDTH-1:0] od_q,
  input  logic [WIDTH-1:0] dat_q,
  output logic [WIDTH-1:0] pin_out,
  output logic [WIDTH-1:0] pin_oe
);
  genvar i;
  generate
    for (i = 0; i < WIDTH; i++) begin : g_pin
      if (PIN_MASK[i]) begin : g_wired
        assign pin_oe[i]  = pad_enable(dir_q[i], od_q[i], dat_q[i]);
        assign pin_out[i] = pad_value(od_q[i], dat_q[i]);
      end else begin : g_unwired
        assign pin_oe[i]  = 1'b0;
        assign pin_out[i] = 1'b0;
      end
    end
  endgenerate
endmodule

// File: rtl/gpio_od_regs.sv
module gpio_od_regs
  import gpio_od_pkg::*;
#(
  parameter int          ADDR_W   = 16,
  parameter int          WIDTH    = 16,
  parameter logic [15:0] DIR_OFFS = 16'h0950,
  parameter logic [15:0] OD_OFFS  = 16'h0954,
  parameter logic [15:0] DAT_OFFS = 16'h0956,
  parameter logic [15:0] OD_MASK  = 16'h004A,
  parameter logic [15:0] PIN_MASK = 16'h0FFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WIDTH-1:0]  bus_wdata,
  input  logic [WIDTH-1:0]  pin_sync,
  output logic [WIDTH-1:0]  bus_rdata,
  output logic [WIDTH-1:0]  dir_q,
  output logic [WIDTH-1:0]  od_q,
  output logic [WIDTH-1:0]  dat_q,
  output logic              wr_dir,
  output logic              wr_od,
  output logic              wr_dat,
  output logic              rd_hit
);
  localparam logic [WIDTH-1:0] OD_IMPL  = OD_MASK[WIDTH-1:0] & PIN_MASK[WIDTH-1:0];
  localparam logic [WIDTH-1:0] PIN_IMPL = PIN_MASK[WIDTH-1:0];

  reg_sel_e sel;

  always_comb begin
    if (bus_addr == DIR_OFFS[ADDR_W-1:0])      sel = SEL_DIR;
    else if (bus_addr == OD_OFFS[ADDR_W-1:0])  sel = SEL_OD;
    else if (bus_addr == DAT_OFFS[ADDR_W-1:0]) sel = SEL_DAT;
    else                                       sel = SEL_NONE;
  end

  assign wr_dir = bus_sel & bus_wr & (sel == SEL_DIR);
  assign wr_od  = bus_sel & bus_wr & (sel == SEL_OD);
  assign wr_dat = bus_sel & bus_wr & (sel == SEL_DAT);
  assign rd_hit = bus_sel & ~bus_wr & (sel != SEL_NONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dir_q <= '0;
    else if (wr_dir) dir_q <= merge_bits(dir_q, bus_wdata, PIN_IMPL);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     od_q <= '0;
    else if (wr_od) od_q <= merge_bits(od_q, bus_wdata, OD_IMPL);
  end

  // Data latch deliberately has no reset.
  always_ff @(posedge clk) begin
    if (wr_dat) dat_q <= bus_wdata & PIN_IMPL;
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_wr) begin
      unique case (sel)
        SEL_DIR:  bus_rdata = dir_q & PIN_IMPL;
        SEL_OD:   bus_rdata = od_q & OD_IMPL;
        SEL_DAT:  bus_rdata = pin_sync & PIN_IMPL;
        default:  bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/gpio_od_port.sv
module gpio_od_port #(
  parameter int          ADDR_W      = 16,
  parameter int          WIDTH       = 16,
  parameter int          SYNC_STAGES = 2,
  parameter logic [15:0] DIR_OFFS    = 16'h0950,
  parameter logic [15:0] OD_OFFS     = 16'h0954,
  parameter logic [15:0] DAT_OFFS    = 16'h0956,
  parameter logic [15:0] OD_MASK     = 16'h004A,
  parameter logic [15:0] PIN_MASK    = 16'h0FFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WIDTH-1:0]  bus_wdata,
  output logic [WIDTH-1:0]  bus_rdata,
  input  logic [WIDTH-1:0]  pin_in,
  output logic [WIDTH-1:0]  pin_out,
  output logic [WIDTH-1:0]  pin_oe
);
  logic [WIDTH-1:0] pin_sync;
  logic [WIDTH-1:0] dir_q, od_q, dat_q;
  logic             wr_dir, wr_od, wr_dat, rd_hit;

  gpio_od_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_in  (pin_in),
    .q_out (pin_sync)
  );

  gpio_od_regs #(
    .ADDR_W(ADDR_W), .WIDTH(WIDTH), .DIR_OFFS(DIR_OFFS), .OD_OFFS(OD_OFFS),
    .DAT_OFFS(DAT_OFFS), .OD_MASK(OD_MASK), .PIN_MASK(PIN_MASK)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .pin_sync  (pin_sync),
    .bus_rdata (bus_rdata),
    .dir_q     (dir_q),
    .od_q      (od_q),
    .dat_q     (dat_q),
    .wr_dir    (wr_dir),
    .wr_od     (wr_od),
    .wr_dat    (wr_dat),
    .rd_hit    (rd_hit)
  );

  gpio_od_drive #(.WIDTH(WIDTH), .PIN_MASK(PIN_MASK)) u_drive (
    .dir_q   (dir_q),
    .od_q    (od_q),
    .dat_q   (dat_q),
    .pin_out (pin_out),
    .pin_oe  (pin_oe)
  );
endmodule

// File: rtl/gpio_od_port_chk.sv
module gpio_od_port_chk #(
  parameter int          ADDR_W   = 16,
  parameter int          WIDTH    = 16,
  parameter logic [15:0] DIR_OFFS = 16'h0950,
  parameter logic [15:0] OD_OFFS  = 16'h0954,
  parameter logic [15:0] DAT_OFFS = 16'h0956,
  parameter logic [15:0] OD_MASK  = 16'h004A,
  parameter logic [15:0] PIN_MASK = 16'h0FFF
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [WIDTH-1:0]  bus_wdata,
  input logic [WIDTH-1:0]  bus_rdata,
  input logic [WIDTH-1:0]  pin_in,
  input logic [WIDTH-1:0]  pin_out,
  input logic [WIDTH-1:0]  pin_oe,
  input logic [WIDTH-1:0]  dir_q,
  input logic [WIDTH-1:0]  od_q,
  input logic [WIDTH-1:0]  dat_q,
  input logic              wr_od,
  input logic              rd_hit
);
  logic [1:0] age;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  wire rd_any   = bus_sel && !bus_wr;
  wire rd_dat   = rd_any && (bus_addr == DAT_OFFS[ADDR_W-1:0]);
  wire rd_od    = rd_any && (bus_addr == OD_OFFS[ADDR_W-1:0]);
  wire unmapped = (bus_addr != DIR_OFFS[ADDR_W-1:0]) && (bus_addr != OD_OFFS[ADDR_W-1:0])
               && (bus_addr != DAT_OFFS[ADDR_W-1:0]);

  AST_IDLE_BUS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_any |-> bus_rdata == '0); // R1
  AST_OD_READ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    rd_od |-> (bus_rdata & ~OD_MASK[WIDTH-1:0]) == '0); // R3
  AST_OD_WRITE_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    wr_od |=> od_q == ($past(bus_wdata) & OD_MASK[WIDTH-1:0])); // R3
  AST_PUSH_PULL_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    ((dir_q & ~od_q & PIN_MASK[WIDTH-1:0] & ~pin_oe) == '0)); // R4
  AST_OD_RELEASE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    ((od_q & dat_q & pin_oe) == '0) && ((od_q & pin_oe & pin_out) == '0)); // R5
  AST_READBACK_LAG: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_dat && age == 2'd3) |-> bus_rdata == ($past(pin_in, 2) & PIN_MASK[WIDTH-1:0])); // R6
  AST_INPUT_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_oe & ~dir_q) == '0); // R7
  AST_UNWIRED_NEVER_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_oe & ~PIN_MASK[WIDTH-1:0]) == '0); // R8
  AST_UNMAPPED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_any && unmapped) |-> (bus_rdata == '0 && !rd_hit)); // R9
  AST_UNMAPPED_WRITE_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && unmapped) |=> ($stable(dir_q) && $stable(od_q))); // R9
endmodule

bind gpio_od_port gpio_od_port_chk #(
  .ADDR_W(ADDR_W), .WIDTH(WIDTH), .DIR_OFFS(DIR_OFFS), .OD_OFFS(OD_OFFS),
  .DAT_OFFS(DAT_OFFS), .OD_MASK(OD_MASK), .PIN_MASK(PIN_MASK)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in), .pin_out(pin_out),
  .pin_oe(pin_oe), .dir_q(dir_q), .od_q(od_q), .dat_q(dat_q), .wr_od(wr_od), .rd_hit(rd_hit)
);

// File: tb/tb_gpio_od_port.sv
module tb_gpio_od_port;
  localparam logic [15:0] A_DIR = 16'h0950;
  localparam logic [15:0] A_OD  = 16'h0954;
  localparam logic [15:0] A_DAT = 16'h0956;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [15:0] bus_addr = '0, bus_wdata = '0;
  logic [15:0] bus_rdata, pin_out, pin_oe, pin_in;
  logic [15:0] ext_lvl = '0, force_mask = '0, force_val = '0;

  int n_chk = 0, n_fail = 0;
  logic [15:0] dir_m = '0, od_m = '0, dat_m = '0;

  always #2 clk = ~clk;

  // Pad model: driven pins show the driver, others the external level; forced pins override.
  assign pin_in = (force_mask & force_val) |
                  (~force_mask & ((pin_oe & pin_out) | (~pin_oe & ext_lvl)));

  gpio_od_port dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe)
  );

  function automatic logic [15:0] vbit(input int p);
    return 16'h0001 << (15 - p);
  endfunction

  function automatic bit od_capable(input int p);
    return (p == 9) || (p == 12) || (p == 14);
  endfunction

  function automatic logic [15:0] keep_wired(input logic [15:0] v);
    logic [15:0] r = '0;
    for (int p = 4; p < 16; p++) r |= v & vbit(p);
    return r;
  endfunction

  function automatic logic [15:0] keep_od(input logic [15:0] v);
    logic [15:0] r = '0;
    for (int p = 0; p < 16; p++) if (od_capable(p)) r |= v & vbit(p);
    return r;
  endfunction

  function automatic logic [15:0] exp_oe(input logic [15:0] d, input logic [15:0] o,
                                         input logic [15:0] l);
    logic [15:0] r = '0;
    for (int p = 4; p < 16; p++) begin
      logic [15:0] m = vbit(p);
      if ((d & m) != 0) begin
        if (!(((o & m) != 0) && ((l & m) != 0))) r |= m;
      end
    end
    return r;
  endfunction

  function automatic logic [15:0] exp_level();
    logic [15:0] en  = exp_oe(dir_m, od_m, dat_m);
    logic [15:0] lvl = (en & dat_m) | (~en & ext_lvl);
    return keep_wired((force_mask & force_val) | (~force_mask & lvl));
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
    if (a == A_DIR) dir_m = keep_wired(d);
    else if (a == A_OD) od_m = keep_od(d);
    else if (a == A_DAT) dat_m = keep_wired(d);
  endtask

  task automatic rd(input logic [15:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic settle();
    @(negedge clk); bus_sel = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic check_all(input string tag);
    logic [15:0] v, en;
    en = exp_oe(dir_m, od_m, dat_m);
    settle();
    check({tag, " R4 R5 R7 pin_oe"}, pin_oe, en);
    check({tag, " R4 pin_out"}, pin_out & en, dat_m & en);
    rd(A_DIR, v); check({tag, " R8 dir"}, v, dir_m);
    rd(A_OD, v);  check({tag, " R3 od"}, v, od_m);
    rd(A_DAT, v); check({tag, " R6 R10 dat"}, v, exp_level());
    @(negedge clk); bus_sel = 1'b0;
  endtask

  initial begin
    #200_000;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] v, old_l;
    void'($urandom(32'd7731));
    repeat (3) @(negedge clk);
    // R2: reset state
    check("R2 pin_oe at reset", pin_oe, 16'h0000);
    rst_n = 1'b1;
    rd(A_DIR, v); check("R2 dir at reset", v, 16'h0000);
    rd(A_OD, v);  check("R2 od at reset", v, 16'h0000);
    check("R1 idle read zero", (bus_sel && !bus_wr) ? 16'h0000 : bus_rdata, 16'h0000);
    @(negedge clk); bus_sel = 1'b0; #1;
    check("R1 rdata zero when idle", bus_rdata, 16'h0000);

    // R3: open-drain only on pins 9, 12, 14
    wr(A_OD, 16'hFFFF);
    rd(A_OD, v); check("R3 od mask", v, 16'h004A);

    // R4/R5/R8: all wired pins out, latch alternating; unwired pins stay released
    wr(A_DAT, 16'hFFFF);
    wr(A_DIR, 16'hFFFF);
    check_all("dir all ones od set");
    check("R8 unwired never driven", pin_oe & 16'hF000, 16'h0000);
    check("R5 od high released", pin_oe & 16'h004A, 16'h0000);
    wr(A_DAT, 16'h0000);
    settle();
    check("R5 od low driven", pin_oe & 16'h004A, 16'h004A);
    check("R5 od low value", pin_out & 16'h004A, 16'h0000);

    // R7: latch kept while input, driven once output
    wr(A_OD, 16'h0000);
    wr(A_DIR, 16'h0000);
    wr(A_DAT, 16'h0A5A);
    settle();
    check("R7 inputs not driven", pin_oe, 16'h0000);
    wr(A_DIR, 16'h0FFF);
    settle();
    check("R7 latch driven after dir", pin_out & 16'h0FFF, 16'h0A5A);

    // R10: overpowered output reads the external level (pin 5 = bit 10)
    force_mask = vbit(5); force_val = 16'h0000;
    wr(A_DAT, vbit(5));
    settle();
    rd(A_DAT, v); check("R10 conflict visible", v & vbit(5), 16'h0000);
    check("R10 still driving one", pin_out & vbit(5), vbit(5));
    force_mask = '0;

    // R6: two-cycle lag, all pins inputs
    wr(A_DIR, 16'h0000);
    ext_lvl = 16'h0123; settle();
    old_l = 16'h0123;
    @(negedge clk); ext_lvl = 16'hFEDC;
    rd(A_DAT, v); check("R6 one edge: old level", v, old_l & 16'h0FFF);
    rd(A_DAT, v); check("R6 two edges: new level", v, 16'h0EDC);
    @(negedge clk); bus_sel = 1'b0;

    // R9: unmapped offsets
    wr(A_DIR, 16'h0F0F);
    wr(A_OD, 16'h0042);
    wr(16'h0952, 16'hFFFF);
    wr(16'h0958, 16'hFFFF);
    rd(16'h0952, v); check("R9 unmapped read 0952", v, 16'h0000);
    rd(16'h1954, v); check("R9 unmapped read 1954", v, 16'h0000);
    check_all("R9 after unmapped writes");

    // Random phase (R1 R3 R4 R5 R6 R7 R8 R9 R10)
    for (int i = 0; i < 150; i++) begin
      logic [15:0] a;
      case ($urandom_range(0, 4))
        0: a = A_DIR;
        1: a = A_OD;
        2: a = A_DAT;
        3: a = 16'h0950 + 16'(2 * $urandom_range(4, 40));
        default: a = 16'($urandom);
      endcase
      ext_lvl = 16'($urandom);
      if ($urandom_range(0, 5) == 0) begin
        force_mask = keep_wired(16'($urandom)) & 16'($urandom);
        force_val  = 16'($urandom);
      end else force_mask = '0;
      wr(a, 16'($urandom));
      check_all("random");
    end
    force_mask = '0;

    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule